// File: doc/BRIEF.md
# Triple-Core Response Comparator

This block judges a group of three identical processor cores that have all been driven with the same test stimuli. Their scan-out responses arrive side by side, one beat per cycle, under a single shared valid strobe and a last-beat marker. Every beat compares the three responses lane by lane. A core that is the lone dissenter at any bit position is remembered for the rest of the test session.

When the last beat of a session has been accepted, the block issues a verdict. The group is clean if nothing disagreed. One named core is faulty if it was the only dissenter in the session. The session is undiagnosable if more than one core was ever the dissenter. When a single faulty core is identified, the tile number that travelled with its response stream is set in a persistent 64-entry fault map. Mapping software reads that map to retire the tile for good.

Top module: `tcmp_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` is 0, `verdict` is 2'b00, `odd_core` is 2'b11 and `fault_map` is all zeros.
- R2: A session in which the three responses agree on every lane of every accepted beat ends with verdict 2'b00 (pass). It also reports `odd_core` 2'b11 and leaves `fault_map` unchanged.
- R3: A session in which exactly one core (stream a, b or c) is ever the minority at some lane ends with verdict 2'b01. In that case `odd_core` is 0 for a, 1 for b and 2 for c.
- R4: Minority status is sticky within a session. A core that dissents on an early beat is still reported faulty even when every later beat agrees.
- R5: A session in which two different cores are each the minority, on the same beat at different lanes or on different beats, ends with verdict 2'b10 (undiagnosable). It reports `odd_core` 2'b11 and sets no bit in `fault_map`.
- R6: A 2'b01 verdict sets bit `tile_x` of `fault_map`, where x is the faulty stream and the tile number is the one presented on the last beat. No bit of `fault_map` ever clears except by reset, and setting an already-set bit leaves the map unchanged.
- R7: `done` is high for exactly one cycle: the cycle that follows the clock edge that accepted a beat with `rsp_valid` and `rsp_last` both high. `verdict` and `odd_core` hold their values until the next `done`.
- R8: Cycles with `rsp_valid` low have no effect on a session, whatever the response and last inputs carry.
- R9: Sessions are independent. Disagreement state is cleared when a last beat is accepted, so a session that starts in the very next cycle is judged only on its own beats.
- R10: A session may consist of a single beat that has both `rsp_valid` and `rsp_last` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Beat of all three responses is present |
| rsp_last | input | 1 | Beat is the final one of the session |
| rsp_a | input | 4 | Response lanes of core stream a |
| rsp_b | input | 4 | Response lanes of core stream b |
| rsp_c | input | 4 | Response lanes of core stream c |
| tile_a | input | 6 | Tile number of stream a (read on last beat) |
| tile_b | input | 6 | Tile number of stream b (read on last beat) |
| tile_c | input | 6 | Tile number of stream c (read on last beat) |
| done | output | 1 | One-cycle verdict strobe |
| verdict | output | 2 | 00 pass, 01 single faulty core, 10 undiagnosable |
| odd_core | output | 2 | Faulty stream 0/1/2, or 3 when none |
| fault_map | output | 64 | Sticky per-tile faulty flags |

## Verification
The verdict issue for one session and the sticky-state restart of the next can fall in the same cycle. The bench provokes this by sending a one-beat session with core a dissenting directly followed by a clean one-beat session. It then expects a single-fault verdict with tile 0 flagged, followed one cycle later by a pass verdict. A map update and an undiagnosable verdict are also driven back to back with an already-flagged tile. The map must not change and must not lose bits.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
    localparam int TILE_W   = 6;
    localparam int N_TILES  = 1 << TILE_W;
    localparam int N_CORES  = 3;

    typedef enum logic [1:0] {
        V_PASS   = 2'b00,
        V_SINGLE = 2'b01,
        V_UNDIAG = 2'b10
    } verdict_e;

    localparam logic [1:0] NO_CORE = 2'b11;

    typedef struct packed {
        verdict_e   verdict;
        logic [1:0] odd;
    } judgement_t;

    // Decide the session outcome from the set of cores that were ever minority.
    function automatic judgement_t judge(input logic [N_CORES-1:0] minor);
        judgement_t j;
        j.odd = NO_CORE;
        case (minor)
            3'b000:  j.verdict = V_PASS;
            3'b001:  begin j.verdict = V_SINGLE; j.odd = 2'd0; end
            3'b010:  begin j.verdict = V_SINGLE; j.odd = 2'd1; end
            3'b100:  begin j.verdict = V_SINGLE; j.odd = 2'd2; end
            default: j.verdict = V_UNDIAG;
        endcase
        return j;
    endfunction
endpackage

// File: rtl/tcmp_lane_cmp.sv
module tcmp_lane_cmp #(
    parameter int LANE_W = 4
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [LANE_W-1:0] c,
    output logic [2:0]        minor
);
    logic [LANE_W-1:0] lone_a, lone_b, lone_c;

    for (genvar i = 0; i < LANE_W; i++) begin : g_lane
        // With binary lanes, at most one stream can stand alone per lane.
        assign lone_a[i] = (a[i] != b[i]) && (b[i] == c[i]);
        assign lone_b[i] = (b[i] != a[i]) && (a[i] == c[i]);
        assign lone_c[i] = (c[i] != a[i]) && (a[i] == b[i]);
    end

    assign minor = {|lone_c, |lone_b, |lone_a};
endmodule

// File: rtl/tcmp_session.sv
module tcmp_session (
    input  logic       clk,
    input  logic       rst,
    input  logic       beat_en,
    input  logic       beat_last,
    input  logic [2:0] beat_minor,
    output logic       fin_valid,
    output logic [2:0] fin_minor
);
    logic [2:0] sticky;

    always_ff @(posedge clk) begin
        if (rst)
            sticky <= '0;
        else if (beat_en && beat_last)
            sticky <= '0;
        else if (beat_en)
            sticky <= sticky | beat_minor;
    end

    assign fin_valid = beat_en && beat_last;
    assign fin_minor = sticky | beat_minor;

    // R9: the next session starts with a clean slate
    p_restart_clean_r9: assert property (@(posedge clk) disable iff (rst)
        beat_en && beat_last |=> sticky == 3'b000);

    // R4: dissent seen earlier in a session is not forgotten mid-session
    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(beat_en && beat_last) |=> (sticky & $past(sticky)) == $past(sticky));

    // R8: idle cycles leave the session state alone
    p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !beat_en |=> $stable(sticky));
endmodule

// File: rtl/tcmp_fault_map.sv
module tcmp_fault_map #(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [DEPTH-1:0] map
);
    always_ff @(posedge clk) begin
        if (rst)
            map <= '0;
        else if (set_en)
            map[set_idx] <= 1'b1;
    end

    // R6: flags never clear outside reset
    p_map_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (map & $past(map)) == $past(map));

    // R6: at most one new flag per cycle
    p_one_new_flag_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(map & ~$past(map)) <= 1);
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
    import tcmp_pkg::*;
#(
    parameter int LANE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rsp_valid,
    input  logic               rsp_last,
    input  logic [LANE_W-1:0]  rsp_a,
    input  logic [LANE_W-1:0]  rsp_b,
    input  logic [LANE_W-1:0]  rsp_c,
    input  logic [TILE_W-1:0]  tile_a,
    input  logic [TILE_W-1:0]  tile_b,
    input  logic [TILE_W-1:0]  tile_c,
    output logic               done,
    output logic [1:0]         verdict,
    output logic [1:0]         odd_core,
    output logic [N_TILES-1:0] fault_map
);
    logic [2:0]        beat_minor;
    logic              fin_valid;
    logic [2:0]        fin_minor;
    judgement_t        jdg;
    logic [TILE_W-1:0] odd_tile;
    logic              flag_en;
    logic [TILE_W-1:0] last_flag;
    verdict_e          verdict_q;

    tcmp_lane_cmp #(.LANE_W(LANE_W)) u_cmp (
        .a     (rsp_a),
        .b     (rsp_b),
        .c     (rsp_c),
        .minor (beat_minor)
    );

    tcmp_session u_sess (
        .clk        (clk),
        .rst        (rst),
        .beat_en    (rsp_valid),
        .beat_last  (rsp_last),
        .beat_minor (beat_minor),
        .fin_valid  (fin_valid),
        .fin_minor  (fin_minor)
    );

    assign jdg = judge(fin_minor);

    always_comb begin
        case (jdg.odd)
            2'd0:    odd_tile = tile_a;
            2'd1:    odd_tile = tile_b;
            default: odd_tile = tile_c;
        endcase
    end

    assign flag_en = fin_valid && (jdg.verdict == V_SINGLE);

    tcmp_fault_map #(.IDX_W(TILE_W)) u_map (
        .clk     (clk),
        .rst     (rst),
        .set_en  (flag_en),
        .set_idx (odd_tile),
        .map     (fault_map)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            verdict_q <= V_PASS;
            odd_core  <= NO_CORE;
            last_flag <= '0;
        end else begin
            done <= fin_valid;
            if (fin_valid) begin
                verdict_q <= jdg.verdict;
                odd_core  <= jdg.odd;
            end
            if (flag_en)
                last_flag <= odd_tile;
        end
    end

    assign verdict = verdict_q;

    // R7: a verdict strobe follows every accepted last beat
    p_done_follows_last_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_last |=> done);

    // R7: no strobe without an accepted last beat
    p_no_spurious_done_r7: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_last) |=> !done);

    // R7: outputs hold between strobes
    p_verdict_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(verdict) && $stable(odd_core));

    // R2: a passing group names no core
    p_pass_no_core_r2: assert property (@(posedge clk) disable iff (rst)
        done && verdict == 2'b00 |-> odd_core == 2'b11);

    // R3: a single-fault verdict names a real stream
    p_single_names_core_r3: assert property (@(posedge clk) disable iff (rst)
        done && verdict == 2'b01 |-> odd_core != 2'b11);

    // R6: the flagged tile is visible together with the strobe
    p_flag_visible_r6: assert property (@(posedge clk) disable iff (rst)
        done && verdict == 2'b01 |-> fault_map[last_flag]);

    // R5: non-single verdicts leave the map untouched
    p_nonsingle_map_r5: assert property (@(posedge clk) disable iff (rst)
        done && verdict != 2'b01 |-> $stable(fault_map));

    // R1: the unused encoding never appears
    p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
        verdict != 2'b11);
endmodule

// File: tb/tb_tcmp_top.sv
module tb_tcmp_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rsp_valid = 1'b0;
    logic        rsp_last = 1'b0;
    logic [3:0]  rsp_a = '0, rsp_b = '0, rsp_c = '0;
    logic [5:0]  tile_a = '0, tile_b = '0, tile_c = '0;
    logic        done;
    logic [1:0]  verdict;
    logic [1:0]  odd_core;
    logic [63:0] fault_map;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_map = '0;

    always #2 clk = ~clk;

    tcmp_top dut (
        .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_last(rsp_last),
        .rsp_a(rsp_a), .rsp_b(rsp_b), .rsp_c(rsp_c),
        .tile_a(tile_a), .tile_b(tile_b), .tile_c(tile_c),
        .done(done), .verdict(verdict), .odd_core(odd_core), .fault_map(fault_map)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tiles(input logic [5:0] ta, input logic [5:0] tb_, input logic [5:0] tc);
        tile_a = ta; tile_b = tb_; tile_c = tc;
    endtask

    // Drive one cycle; the posedge inside accepts it, return at the next negedge.
    task automatic beat(input bit v, input bit l, input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
        rsp_valid = v; rsp_last = l; rsp_a = a; rsp_b = b; rsp_c = c;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_last = 1'b0;
    endtask

    task automatic expect_end(input string req, input logic [1:0] v, input logic [1:0] o);
        check(done == 1'b1, req, {63'b0, done}, 64'd1);
        check(verdict == v, req, {62'b0, verdict}, {62'b0, v});
        check(odd_core == o, req, {62'b0, odd_core}, {62'b0, o});
        check(fault_map == exp_map, req, fault_map, exp_map);
    endtask

    task automatic t_reset;
        check(done == 1'b0, "R1", {63'b0, done}, 64'd0);
        check(verdict == 2'b00, "R1", {62'b0, verdict}, 64'd0);
        check(odd_core == 2'b11, "R1", {62'b0, odd_core}, 64'd3);
        check(fault_map == '0, "R1", fault_map, 64'd0);
    endtask

    task automatic t_pass;
        tiles(6'd5, 6'd6, 6'd7);
        beat(1, 0, 4'hA, 4'hA, 4'hA);
        beat(1, 0, 4'h3, 4'h3, 4'h3);
        beat(1, 1, 4'hF, 4'hF, 4'hF);
        expect_end("R2", 2'b00, 2'b11);
    endtask

    task automatic t_single_b;
        tiles(6'd10, 6'd11, 6'd12);
        beat(1, 0, 4'h0, 4'h0, 4'h0);
        beat(1, 0, 4'h5, 4'h7, 4'h5);
        beat(1, 1, 4'h9, 4'h9, 4'h9);
        exp_map[11] = 1'b1;
        expect_end("R3", 2'b01, 2'd1);
        @(negedge clk);
        check(done == 1'b0, "R7", {63'b0, done}, 64'd0);
        check(verdict == 2'b01 && odd_core == 2'd1, "R7", {60'b0, verdict, odd_core}, 64'h5);
    endtask

    task automatic t_sticky_c;
        tiles(6'd20, 6'd21, 6'd63);
        beat(1, 0, 4'h1, 4'h1, 4'h0);
        beat(1, 0, 4'h2, 4'h2, 4'h2);
        beat(1, 0, 4'h4, 4'h4, 4'h4);
        beat(1, 1, 4'h8, 4'h8, 4'h8);
        exp_map[63] = 1'b1;
        expect_end("R4", 2'b01, 2'd2);
    endtask

    task automatic t_undiag_beats;
        tiles(6'd30, 6'd31, 6'd32);
        beat(1, 0, 4'h1, 4'h0, 4'h0);
        beat(1, 1, 4'h6, 4'h2, 4'h6);
        expect_end("R5", 2'b10, 2'b11);
    endtask

    task automatic t_undiag_lanes;
        tiles(6'd40, 6'd41, 6'd42);
        beat(1, 1, 4'h1, 4'h0, 4'h8);
        expect_end("R5", 2'b10, 2'b11);
    endtask

    task automatic t_idle_ignored;
        tiles(6'd1, 6'd2, 6'd3);
        beat(1, 0, 4'hC, 4'hC, 4'hC);
        rsp_valid = 1'b0; rsp_last = 1'b1; rsp_a = 4'h1; rsp_b = 4'h2; rsp_c = 4'h4;
        @(negedge clk);
        check(done == 1'b0, "R8", {63'b0, done}, 64'd0);
        @(negedge clk);
        rsp_last = 1'b0;
        beat(1, 1, 4'hD, 4'hD, 4'hD);
        expect_end("R8", 2'b00, 2'b11);
    endtask

    task automatic t_back_to_back;
        tiles(6'd0, 6'd9, 6'd8);
        beat(1, 1, 4'h2, 4'h0, 4'h0);
        exp_map[0] = 1'b1;
        expect_end("R10", 2'b01, 2'd0);
        beat(1, 1, 4'h7, 4'h7, 4'h7);
        expect_end("R9", 2'b00, 2'b11);
    endtask

    task automatic t_reflag;
        tiles(6'd50, 6'd11, 6'd51);
        beat(1, 1, 4'h0, 4'hF, 4'h0);
        expect_end("R6", 2'b01, 2'd1);
        tiles(6'd11, 6'd52, 6'd53);
        beat(1, 1, 4'h3, 4'h1, 4'h2);
        expect_end("R6", 2'b10, 2'b11);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset;
                rst = 1'b0;
                t_reset;
                t_pass;
                t_single_b;
                t_sticky_c;
                t_undiag_beats;
                t_undiag_lanes;
                t_idle_ignored;
                t_back_to_back;
                t_reflag;
                repeat (2) @(negedge clk);
                check(fault_map == exp_map, "R6", fault_map, exp_map);
            end
            begin
                repeat (5000) @(posedge clk);
                check(1'b0, "watchdog", 64'd0, 64'd1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule